// File: doc/BRIEF.md
# UART Transmit Queue and Serializer

This block is the transmit half of a memory-mapped UART. Each write strobe pushes one byte into a transmit FIFO that is 32 entries deep by default. A serializer takes bytes from the head of the FIFO and shifts them onto an idle-high line. Every character is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit.

Bit timing comes from a 20-bit phase accumulator. Each clock it adds a 16-bit increment taken from the upper half of a 32-bit control word. The overflow of the accumulator is the bit tick, so a bit lasts 2^20 / increment clock cycles. Bit 0 of the same control word enables transmission. While that bit is low, the accumulator holds at zero and nothing leaves the FIFO.

Several outputs go to the interrupt controller and the register file: full and empty flags, a 5-bit level readout, a watermark indication that compares the level against a programmable threshold, and a one-cycle pulse each time the FIFO becomes empty. A flush input empties the FIFO at once.

Top module: `uart_txq_top`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, level_o is 0, tx_o is 1 and empty_evt_o is 0.
- R2: A write strobe on a FIFO that is not full raises the level by one in the next cycle. level_o carries the low 5 bits of the level, so a level of 32 reads as 0 with full_o at 1.
- R3: full_o is 1 exactly when the level equals the depth (32). A write strobe while full_o is 1 is dropped and the level is unchanged.
- R4: A flush strobe sets the level to 0 in the next cycle. A write strobe in the same cycle is dropped.
- R5: wmark_o is 1 exactly when the level is at or above wmark_thresh_i (6 bits, 0 to 32). It falls as soon as the level drops below the threshold.
- R6: empty_evt_o pulses high for exactly one cycle in the cycle after the level goes from nonzero to zero, whether by draining or by flush, and empty_o is 1 whenever empty_evt_o is 1.
- R7: Each character on tx_o is a 0 start bit, then data bits 0 through 7, then a 1 stop bit. The line is 1 when idle.
- R8: Each bit lasts 2^20 / ctrl_i[31:16] clock cycles. For example, an increment of 0x4000 gives 64 cycles.
- R9: While ctrl_i[0] is 0, tx_o does not change and the level does not fall.
- R10: Bytes leave in the order they were written, back to back, with no idle gap between stop and start while data remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Bit 0 transmit enable; bits 31:16 baud increment |
| wr_en_i | input | 1 | Push strobe |
| wr_data_i | input | 8 | Byte to push |
| flush_i | input | 1 | Empty the FIFO |
| wmark_thresh_i | input | 6 | Watermark threshold level |
| tx_o | output | 1 | Serial line |
| level_o | output | 5 | FIFO level, low 5 bits |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| wmark_o | output | 1 | Level at or above threshold |
| empty_evt_o | output | 1 | One-cycle pulse on becoming empty |

## Verification
The bench fills the FIFO one byte at a time up to the wrap at 32. A design that lets the 5-bit readout stand in for the level would show full as empty there. An extra write at that point must be dropped; a design that takes it would overwrite the head byte. At every level the bench sweeps the watermark threshold through all 33 values, which catches an off-by-one that uses a strict comparison. It flushes while writing, where a design that gives the write priority leaves a level of one. It decodes frames at two baud increments and measures the low time of a zero byte, so a wrong bit period, a reversed bit order or a missing stop bit shows up as a wrong byte or a wrong duration. It also holds the enable low with data queued, which exposes a serializer that ignores the enable.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  localparam int unsigned NCO_W    = 20;
  localparam int unsigned INC_W    = 16;
  localparam int unsigned FRAME_W  = 10;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned INC_LSB  = 16;
endpackage

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic push_ok, pop_ok;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (count_q == CW'(DEPTH)));
  assert_flush_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/uart_txq_nco.sv
module uart_txq_nco
  import uart_txq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [INC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [NCO_W-1:0] acc_q;
  logic [NCO_W:0]   sum;

  assign sum    = {1'b0, acc_q} + (NCO_W+1)'(inc_i);
  assign tick_o = run_i && sum[NCO_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!run_i) acc_q <= '0;
    else             acc_q <= sum[NCO_W-1:0];
  end
endmodule

// File: rtl/uart_txq_ser.sv
module uart_txq_ser
  import uart_txq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              pop_o,
  output logic              tx_o
);
  localparam int unsigned BC_W = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [BC_W-1:0]    bit_q;
  logic               busy_q;
  logic               slot_free;

  assign slot_free = !busy_q || (bit_q == LAST);
  assign pop_o     = tick_i && slot_free && avail_i;
  assign tx_o      = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else if (tick_i) begin
      if (!slot_free) begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        bit_q <= bit_q + 1'b1;
      end else if (avail_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        bit_q  <= '0;
        busy_q <= 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assert_idle_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && !busy_q) |=> (tx_o == 1'b0));
endmodule

// File: rtl/uart_txq_top.sv
module uart_txq_top
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH),
  localparam int unsigned CW   = LW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              flush_i,
  input  logic [CW-1:0]     wmark_thresh_i,
  output logic              tx_o,
  output logic [LW-1:0]     level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              wmark_o,
  output logic              empty_evt_o
);
  logic              tick, pop, tx_en;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     count;
  logic              empty_q;

  assign tx_en = ctrl_i[EN_BIT];

  uart_txq_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(wr_en_i), .data_i(wr_data_i), .pop_i(pop), .flush_i,
    .head_o(head), .count_o(count), .full_o, .empty_o
  );

  uart_txq_nco u_nco (
    .clk_i, .rst_ni,
    .run_i(tx_en), .inc_i(ctrl_i[INC_LSB +: INC_W]), .tick_o(tick)
  );

  uart_txq_ser u_ser (
    .clk_i, .rst_ni,
    .tick_i(tick), .avail_i(!empty_o), .data_i(head), .pop_o(pop), .tx_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_q <= 1'b1;
    else         empty_q <= empty_o;
  end

  assign level_o     = count[LW-1:0];
  assign wmark_o     = (count >= wmark_thresh_i);
  assign empty_evt_o = empty_o && !empty_q;

  assert_hold_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |=> $stable(tx_o));
  assert_no_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en && !flush_i) |=> (count >= $past(count)));
  assert_evt_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_evt_o |-> empty_o);
  assert_evt_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_evt_o |=> !empty_evt_o);
endmodule

// File: tb/tb_uart_txq_top.sv
module tb_uart_txq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        flush = 1'b0;
  logic [5:0]  thresh = 6'd4;
  logic        tx, full, empty, wmark, evt;
  logic [4:0]  level;

  int checks = 0;
  int errors = 0;
  int evt_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_txq_top #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .flush_i(flush), .wmark_thresh_i(thresh),
    .tx_o(tx), .level_o(level), .full_o(full), .empty_o(empty),
    .wmark_o(wmark), .empty_evt_o(evt)
  );

  always @(negedge clk) if (rst_n && evt) evt_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic decode(input int p, output logic [7:0] b);
    int guard = 0;
    b = '0;
    while (tx !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    chk(guard < 20000, "R7 start seen", guard, 0);
    repeat (p/2) @(negedge clk);
    chk(tx == 1'b0, "R7 start bit", tx, 0);
    for (int k = 0; k < 8; k++) begin
      repeat (p) @(negedge clk);
      b[k] = tx;
    end
    repeat (p) @(negedge clk);
    chk(tx == 1'b1, "R7 stop bit", tx, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int lowc;
    repeat (3) @(negedge clk);
    chk(empty == 1 && full == 0 && level == 0 && tx == 1 && evt == 0, "R1 reset state",
        {empty, full, tx, evt}, 4'b1010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1 && evt == 0, "R1 after release", {empty, evt}, 2'b10);

    // fill and sweep threshold at every level
    for (int n = 0; n <= DEPTH; n++) begin
      if (n > 0) push(8'(n));
      chk(level == 5'(n), "R2 level", level, n % 32);
      chk(full == (n == DEPTH), "R3 full", full, n == DEPTH);
      chk(empty == (n == 0), "R2 empty", empty, n == 0);
      for (int t = 0; t <= DEPTH; t++) begin
        thresh = 6'(t);
        #1;
        chk(wmark == (n >= t), "R5 watermark", wmark, n >= t);
      end
    end
    thresh = 6'd4;
    push(8'hEE);
    chk(full == 1 && level == 0, "R3 drop on full", level, 0);

    evt_cnt = 0;
    do_flush();
    chk(empty == 1 && level == 0, "R4 flush", level, 0);
    chk(evt == 1, "R6 pulse on flush", evt, 1);
    @(negedge clk);
    chk(evt == 0 && evt_cnt == 1, "R6 single pulse", evt_cnt, 1);

    push(8'h11);
    push(8'h22);
    wr_en = 1'b1; wr_data = 8'h33; flush = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; flush = 1'b0;
    chk(level == 0 && empty == 1, "R4 flush beats write", level, 0);

    // disabled: no drain
    push(8'hA5); push(8'h3C); push(8'h01);
    ctrl = {16'h8000, 15'd0, 1'b0};
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (tx != 1'b1 || level != 5'd3) begin
        chk(1'b0, "R9 held while disabled", level, 3);
        break;
      end
    end
    chk(level == 3 && tx == 1, "R9 held while disabled", level, 3);

    // enable: ordered back-to-back drain, period 32
    evt_cnt = 0;
    ctrl = {16'h8000, 15'd0, 1'b1};
    decode(32, got); chk(got == 8'hA5, "R10 byte0", got, 8'hA5);
    decode(32, got); chk(got == 8'h3C, "R10 byte1", got, 8'h3C);
    decode(32, got); chk(got == 8'h01, "R10 byte2", got, 8'h01);
    chk(empty == 1 && evt_cnt == 1, "R6 drain event", evt_cnt, 1);
    repeat (40) @(negedge clk);
    chk(tx == 1, "R7 idle high", tx, 1);

    // period 64
    ctrl = {16'h4000, 15'd0, 1'b0};
    push(8'h55); push(8'h00);
    @(negedge clk);
    ctrl[0] = 1'b1;
    decode(64, got); chk(got == 8'h55, "R8 byte at 64", got, 8'h55);
    while (tx !== 1'b0) @(negedge clk);
    lowc = 1;
    forever begin
      @(negedge clk);
      if (tx == 1'b0) lowc++; else break;
    end
    chk(lowc == 9*64, "R8 zero byte low time", lowc, 9*64);
    repeat (100) @(negedge clk);
    chk(empty == 1 && tx == 1, "R10 drained", empty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule